// File: doc/BRIEF.md
# Fixed-Point FDTD Field Update Engine

This engine advances a pseudo-two-dimensional finite-difference time-domain grid by one time step per request. The grid is NX by NY cells in the plane, and its third axis is fixed at two layers. Each layer is updated on its own, using only in-plane neighbours. Three field components are kept in on-chip memories: the electric component Ez and the magnetic components Hx and Hy. Every value is a signed 30-bit fixed-point number with 26 fractional bits. Field values stay between -1 and +1 in normal use, so three integer bits give enough headroom.

A sequencer handles each step in two phases. In the magnetic phase, the Hx and Hy update pipelines visit every cell, one cell per clock. When all magnetic writes have landed, the electric phase runs the Ez pipeline over the grid in the same way. Each update forms `new = a*old + b*diff`, where `diff` is a difference of neighbouring values of the opposite field. The sum is rounded back to 26 fractional bits and clamped to the 30-bit range. Cells on the outer ring of each layer are written with zero.

A host port loads and reads field cells while the engine is idle. The four update coefficients are sampled when a step starts.

Top module: `fdtd_step_engine`

## Requirements
- R1: Values and coefficients are signed two's complement, 30 bits wide, with 26 fractional bits. An update adds a*old and b*diff at full precision, adds 2^25, and then shifts right arithmetically by 26 bits. This rounds half up.
- R2: A rounded result above 2^29-1 becomes 2^29-1. A rounded result below -2^29 becomes -2^29.
- R3: In the magnetic phase, each interior cell c is updated with coefficients (ah, bh) as follows:
  - Hx[c] uses diff = Ez[c] - Ez[c+NX].
  - Hy[c] uses diff = Ez[c+1] - Ez[c].
  - Both read Ez values from before the step.
- R4: Every magnetic write of a step completes before any electric read of that step. Each interior Ez[c] is updated with coefficients (ae, be) using diff = (Hy[c]-Hy[c-1]) - (Hx[c]-Hx[c-NX]), taken from the new H values. Magnetic and electric write-backs never occur in the same cycle.
- R5: Cell address is z*NX*NY + y*NX + x, with z in {0,1}. After a step, every cell with x=0, x=NX-1, y=0 or y=NY-1 holds zero in all three fields, whatever it held before. Each layer uses only its own cells.
- R6: A step begins at the clock edge that samples step_start_i high while idle. step_done_o is high for exactly one cycle, 2*(NC+4) edges later, where NC = 2*NX*NY. busy_o is high from the start edge until done rises.
- R7: The coefficients are sampled at the start edge. Changing the coefficient inputs during a step has no effect on that step.
- R8: While idle, host_we_i writes host_wdata_i into the field chosen by host_sel_i (0=Ez, 1=Hx, 2=Hy) at host_addr_i. host_rdata_o shows the cell addressed in the previous cycle.
- R9: While busy, host writes and further step_start_i pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_start_i | input | 1 | Request one time step |
| cfg_ah_i | input | DW | Magnetic self coefficient |
| cfg_bh_i | input | DW | Magnetic curl coefficient |
| cfg_ae_i | input | DW | Electric self coefficient |
| cfg_be_i | input | DW | Electric curl coefficient |
| host_we_i | input | 1 | Host cell write |
| host_sel_i | input | 2 | Field select: 0=Ez, 1=Hx, 2=Hy |
| host_addr_i | input | AW | Host cell address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, one cycle after the address |
| busy_o | output | 1 | Step in progress |
| step_done_o | output | 1 | One-cycle pulse when the step finishes |

## Verification
With the default 16x16x2 grid, step_done_o is due 1032 edges after the start edge, so the bench checks step_done_o and busy_o at every falling edge across the whole step. A cell written in the magnetic phase lands five edges after its issue cycle. The sequencer's four-cycle drain puts the first electric read one edge after the last magnetic write, so the cell values read back after done reflect the full two-phase order. Host reads return data on the edge after the address is driven and are sampled at the following falling edge. Every cell of all three fields is compared with a behavioural fixed-point model after each step.

// File: rtl/fdtd_pkg.sv
package fdtd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_H_RUN, ST_H_WAIT, ST_E_RUN, ST_E_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    FLD_EZ = 2'd0, FLD_HX = 2'd1, FLD_HY = 2'd2
  } field_e;

  // register stages between issue and write-back
  localparam int PIPE_LAT = 4;
endpackage

// File: rtl/fdtd_field_mem.sv
module fdtd_field_mem #(
  parameter int DW    = 30,
  parameter int DEPTH = 512,
  parameter int NRD   = 1,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][DW-1:0]   rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // replicated synchronous read ports, old data on same-address write
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk_i) rd_q <= mem_q[raddr_i[p]];
    assign rdata_o[p] = rd_q;
  end
endmodule

// File: rtl/fdtd_update_unit.sv
module fdtd_update_unit #(
  parameter int DW = 30,
  parameter int FW = 26
) (
  input  logic                 clk_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] old_i,
  input  logic signed [DW-1:0] p0_i,
  input  logic signed [DW-1:0] n0_i,
  input  logic signed [DW-1:0] p1_i,
  input  logic signed [DW-1:0] n1_i,
  output logic signed [DW-1:0] res_o
);
  localparam int DDW = DW + 2;
  localparam int PAW = 2 * DW;
  localparam int PBW = DW + DDW;
  localparam int SW  = PBW + 1;
  localparam logic signed [SW-1:0] RND = {{(SW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  logic signed [DDW-1:0] diff_q;
  logic signed [DW-1:0]  old_q;
  logic signed [PAW-1:0] pa_q;
  logic signed [PBW-1:0] pb_q;
  logic signed [DW-1:0]  res_q;

  logic signed [SW-1:0]  sum, sh;
  logic [SW-DW:0]        hi;
  logic                  fits;

  // stage 1: neighbour difference
  always_ff @(posedge clk_i) begin
    diff_q <= DDW'(p0_i) - DDW'(n0_i) + DDW'(p1_i) - DDW'(n1_i);
    old_q  <= old_i;
  end

  // stage 2: products
  always_ff @(posedge clk_i) begin
    pa_q <= a_i * old_q;
    pb_q <= b_i * diff_q;
  end

  // stage 3: round half up, saturate
  always_comb begin
    sum  = SW'(pa_q) + SW'(pb_q) + RND;
    sh   = sum >>> FW;
    hi   = sh[SW-1:DW-1];
    fits = (&hi) | ~(|hi);
  end

  always_ff @(posedge clk_i) begin
    if (fits)        res_q <= sh[DW-1:0];
    else if (sh[SW-1]) res_q <= {1'b1, {(DW-1){1'b0}}};
    else             res_q <= {1'b0, {(DW-1){1'b1}}};
  end

  assign res_o = res_q;
endmodule

// File: rtl/fdtd_seq.sv
module fdtd_seq
  import fdtd_pkg::*;
#(
  parameter int NX  = 16,
  parameter int NY  = 16,
  parameter int NZ  = 2,
  parameter int LAT = PIPE_LAT,
  parameter int AW  = $clog2(NX*NY*NZ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] own_o,
  output logic [AW-1:0] xp_o,
  output logic [AW-1:0] xm_o,
  output logic [AW-1:0] yp_o,
  output logic [AW-1:0] ym_o,
  output logic          wr_v_o,
  output logic          wr_e_o,
  output logic          wr_edge_o,
  output logic [AW-1:0] wr_addr_o
);
  localparam int XW    = (NX > 1) ? $clog2(NX) : 1;
  localparam int YW    = (NY > 1) ? $clog2(NY) : 1;
  localparam int ZW    = (NZ > 1) ? $clog2(NZ) : 1;
  localparam int LW    = $clog2(LAT + 1);
  localparam int PLANE = NX * NY;
  localparam logic [XW-1:0] X_LAST = XW'(NX - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(NY - 1);
  localparam logic [ZW-1:0] Z_LAST = ZW'(NZ - 1);
  localparam logic [LW-1:0] W_LAST = LW'(LAT - 1);

  seq_state_e    state_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [ZW-1:0] z_q;
  logic [LW-1:0] wc_q;
  logic          done_q;

  logic issue, iss_e, last_cell, on_edge;
  logic [AW-1:0] own;

  assign issue     = (state_q == ST_H_RUN) || (state_q == ST_E_RUN);
  assign iss_e     = (state_q == ST_E_RUN);
  assign last_cell = (x_q == X_LAST) && (y_q == Y_LAST) && (z_q == Z_LAST);
  assign on_edge   = (x_q == '0) || (x_q == X_LAST) || (y_q == '0) || (y_q == Y_LAST);
  assign own       = AW'(z_q) * AW'(PLANE) + AW'(y_q) * AW'(NX) + AW'(x_q);

  // neighbours clamped to own cell on the ring; those results are discarded
  always_comb begin
    own_o = own;
    xp_o  = on_edge ? own : own + AW'(1);
    xm_o  = on_edge ? own : own - AW'(1);
    yp_o  = on_edge ? own : own + AW'(NX);
    ym_o  = on_edge ? own : own - AW'(NX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      wc_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_H_RUN;
            x_q     <= '0;
            y_q     <= '0;
            z_q     <= '0;
          end
        end
        ST_H_RUN, ST_E_RUN: begin
          if (x_q == X_LAST) begin
            x_q <= '0;
            if (y_q == Y_LAST) begin
              y_q <= '0;
              z_q <= (z_q == Z_LAST) ? '0 : z_q + ZW'(1);
            end else begin
              y_q <= y_q + YW'(1);
            end
          end else begin
            x_q <= x_q + XW'(1);
          end
          if (last_cell) begin
            state_q <= (state_q == ST_H_RUN) ? ST_H_WAIT : ST_E_WAIT;
            wc_q    <= '0;
          end
        end
        ST_H_WAIT: begin
          wc_q <= wc_q + LW'(1);
          if (wc_q == W_LAST) state_q <= ST_E_RUN;
        end
        ST_E_WAIT: begin
          wc_q <= wc_q + LW'(1);
          if (wc_q == W_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // write-back tag delayed to match the datapath depth
  logic [LAT-1:0]         v_q, e_q, g_q;
  logic [LAT-1:0][AW-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      e_q <= '0;
      g_q <= '0;
      a_q <= '0;
    end else begin
      v_q <= {v_q[LAT-2:0], issue};
      e_q <= {e_q[LAT-2:0], iss_e};
      g_q <= {g_q[LAT-2:0], on_edge};
      a_q <= {a_q[LAT-2:0], own};
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign wr_v_o    = v_q[LAT-1];
  assign wr_e_o    = e_q[LAT-1];
  assign wr_edge_o = g_q[LAT-1];
  assign wr_addr_o = a_q[LAT-1];
endmodule

// File: rtl/fdtd_step_engine.sv
module fdtd_step_engine
  import fdtd_pkg::*;
#(
  parameter int  NX  = 16,
  parameter int  NY  = 16,
  parameter int  DW  = 30,
  parameter int  FW  = 26,
  localparam int NZ  = 2,
  localparam int NC  = NX * NY * NZ,
  localparam int AW  = $clog2(NC),
  localparam int LAT = PIPE_LAT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_start_i,
  input  logic [DW-1:0] cfg_ah_i,
  input  logic [DW-1:0] cfg_bh_i,
  input  logic [DW-1:0] cfg_ae_i,
  input  logic [DW-1:0] cfg_be_i,
  input  logic          host_we_i,
  input  logic [1:0]    host_sel_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          busy_o,
  output logic          step_done_o
);
  logic          busy, done;
  logic [AW-1:0] own, xp, xm, yp, ym, wr_addr;
  logic          wr_v, wr_e, wr_edge;

  fdtd_seq #(.NX(NX), .NY(NY), .NZ(NZ), .LAT(LAT), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .start_i   (step_start_i),
    .busy_o    (busy),
    .done_o    (done),
    .own_o     (own),
    .xp_o      (xp),
    .xm_o      (xm),
    .yp_o      (yp),
    .ym_o      (ym),
    .wr_v_o    (wr_v),
    .wr_e_o    (wr_e),
    .wr_edge_o (wr_edge),
    .wr_addr_o (wr_addr)
  );

  // per-run coefficients
  logic signed [DW-1:0] ah_q, bh_q, ae_q, be_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ah_q <= '0;
      bh_q <= '0;
      ae_q <= '0;
      be_q <= '0;
    end else if (step_start_i && !busy) begin
      ah_q <= cfg_ah_i;
      bh_q <= cfg_bh_i;
      ae_q <= cfg_ae_i;
      be_q <= cfg_be_i;
    end
  end

  logic       idle, hw;
  logic [1:0] sel_q;
  logic [AW-1:0] p0a;
  assign idle = !busy;
  assign hw   = host_we_i && idle;
  assign p0a  = idle ? host_addr_i : own;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= host_sel_i;
  end

  // write ports
  logic          ez_pwe, h_pwe;
  logic          ez_we, hx_we, hy_we;
  logic [AW-1:0] ez_wa, hx_wa, hy_wa;
  logic [DW-1:0] ez_wd, hx_wd, hy_wd;
  logic signed [DW-1:0] ez_res, hx_res, hy_res;

  assign ez_pwe = wr_v && wr_e;
  assign h_pwe  = wr_v && !wr_e;

  always_comb begin
    ez_we = ez_pwe || (hw && host_sel_i == FLD_EZ);
    hx_we = h_pwe  || (hw && host_sel_i == FLD_HX);
    hy_we = h_pwe  || (hw && host_sel_i == FLD_HY);
    ez_wa = ez_pwe ? wr_addr : host_addr_i;
    hx_wa = h_pwe  ? wr_addr : host_addr_i;
    hy_wa = h_pwe  ? wr_addr : host_addr_i;
    ez_wd = ez_pwe ? (wr_edge ? '0 : ez_res) : host_wdata_i;
    hx_wd = h_pwe  ? (wr_edge ? '0 : hx_res) : host_wdata_i;
    hy_wd = h_pwe  ? (wr_edge ? '0 : hy_res) : host_wdata_i;
  end

  logic [2:0][DW-1:0] ez_rd;
  logic [1:0][DW-1:0] hx_rd, hy_rd;

  fdtd_field_mem #(.DW(DW), .DEPTH(NC), .NRD(3), .AW(AW)) u_ez_mem (
    .clk_i, .we_i(ez_we), .waddr_i(ez_wa), .wdata_i(ez_wd),
    .raddr_i({yp, xp, p0a}), .rdata_o(ez_rd)
  );
  fdtd_field_mem #(.DW(DW), .DEPTH(NC), .NRD(2), .AW(AW)) u_hx_mem (
    .clk_i, .we_i(hx_we), .waddr_i(hx_wa), .wdata_i(hx_wd),
    .raddr_i({ym, p0a}), .rdata_o(hx_rd)
  );
  fdtd_field_mem #(.DW(DW), .DEPTH(NC), .NRD(2), .AW(AW)) u_hy_mem (
    .clk_i, .we_i(hy_we), .waddr_i(hy_wa), .wdata_i(hy_wd),
    .raddr_i({xm, p0a}), .rdata_o(hy_rd)
  );

  logic signed [DW-1:0] ez_c, ez_xp, ez_yp, hx_c, hx_ym, hy_c, hy_xm;
  assign ez_c  = ez_rd[0];
  assign ez_xp = ez_rd[1];
  assign ez_yp = ez_rd[2];
  assign hx_c  = hx_rd[0];
  assign hx_ym = hx_rd[1];
  assign hy_c  = hy_rd[0];
  assign hy_xm = hy_rd[1];

  fdtd_update_unit #(.DW(DW), .FW(FW)) u_hx_upd (
    .clk_i, .a_i(ah_q), .b_i(bh_q), .old_i(hx_c),
    .p0_i(ez_c), .n0_i(ez_yp), .p1_i('0), .n1_i('0), .res_o(hx_res)
  );
  fdtd_update_unit #(.DW(DW), .FW(FW)) u_hy_upd (
    .clk_i, .a_i(ah_q), .b_i(bh_q), .old_i(hy_c),
    .p0_i(ez_xp), .n0_i(ez_c), .p1_i('0), .n1_i('0), .res_o(hy_res)
  );
  fdtd_update_unit #(.DW(DW), .FW(FW)) u_ez_upd (
    .clk_i, .a_i(ae_q), .b_i(be_q), .old_i(ez_c),
    .p0_i(hy_c), .n0_i(hy_xm), .p1_i(hx_ym), .n1_i(hx_c), .res_o(ez_res)
  );

  always_comb begin
    unique case (sel_q)
      FLD_EZ:  host_rdata_o = ez_rd[0];
      FLD_HX:  host_rdata_o = hx_rd[0];
      default: host_rdata_o = hy_rd[0];
    endcase
  end

  assign busy_o      = busy;
  assign step_done_o = done;
endmodule

// File: rtl/fdtd_step_engine_chk.sv
module fdtd_step_engine_chk #(
  parameter int NC  = 512,
  parameter int LAT = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic step_start_i,
  input logic busy_o,
  input logic step_done_o,
  input logic h_we_i,
  input logic e_we_i
);
  localparam int STEP_CYC = 2 * (NC + LAT);
  localparam int CW       = $clog2(STEP_CYC + 2);

  logic [CW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (!busy_o) run_q <= '0;
    else              run_q <= run_q + CW'(1);
  end

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !step_done_o);

  assert_done_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> (run_q == CW'(STEP_CYC)) && !busy_o);

  assert_start_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(step_start_i));

  assert_phase_split_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h_we_i && e_we_i));

  assert_e_after_h_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(e_we_i) |-> !$past(h_we_i));

  assert_pipe_write_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_we_i || e_we_i) |-> busy_o);
endmodule

bind fdtd_step_engine fdtd_step_engine_chk #(.NC(NC), .LAT(LAT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_start_i (step_start_i),
  .busy_o       (busy_o),
  .step_done_o  (step_done_o),
  .h_we_i       (h_pwe),
  .e_we_i       (ez_pwe)
);

// File: tb/fdtd_step_engine_tb_top.sv
module fdtd_step_engine_tb_top;
  localparam int NX    = 16;
  localparam int NY    = 16;
  localparam int PLANE = NX * NY;
  localparam int NC    = PLANE * 2;
  localparam int AW    = $clog2(NC);
  localparam int DW    = 30;
  localparam int LIM   = 2 * (NC + 4);
  localparam longint ONE  = 64'sd1 <<< 26;
  localparam longint MAXV = (64'sd1 <<< 29) - 1;
  localparam longint MINV = -(64'sd1 <<< 29);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          step_start = 1'b0;
  logic [DW-1:0] cah = '0, cbh = '0, cae = '0, cbe = '0;
  logic          host_we = 1'b0;
  logic [1:0]    host_sel = '0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          busy, done;

  fdtd_step_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .step_start_i(step_start),
    .cfg_ah_i(cah), .cfg_bh_i(cbh), .cfg_ae_i(cae), .cfg_be_i(cbe),
    .host_we_i(host_we), .host_sel_i(host_sel), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .busy_o(busy), .step_done_o(done)
  );

  int checks = 0;
  int errors = 0;
  longint mez [NC];
  longint mhx [NC];
  longint mhy [NC];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint fx_upd(longint a, longint b, longint old, longint diff);
    longint s;
    s = a * old + b * diff + (64'sd1 <<< 25);
    s = s >>> 26;
    if (s > MAXV) s = MAXV;
    if (s < MINV) s = MINV;
    return s;
  endfunction

  function automatic bit ring(int c);
    int x, y;
    x = c % NX;
    y = (c / NX) % NY;
    return (x == 0) || (x == NX - 1) || (y == 0) || (y == NY - 1);
  endfunction

  task automatic model_step(longint ah, longint bh, longint ae, longint be);
    longint nhx [NC];
    longint nhy [NC];
    longint nez [NC];
    for (int c = 0; c < NC; c++) begin
      if (ring(c)) begin
        nhx[c] = 0;
        nhy[c] = 0;
      end else begin
        nhx[c] = fx_upd(ah, bh, mhx[c], mez[c] - mez[c+NX]);
        nhy[c] = fx_upd(ah, bh, mhy[c], mez[c+1] - mez[c]);
      end
    end
    for (int c = 0; c < NC; c++) begin
      mhx[c] = nhx[c];
      mhy[c] = nhy[c];
    end
    for (int c = 0; c < NC; c++) begin
      if (ring(c)) nez[c] = 0;
      else nez[c] = fx_upd(ae, be, mez[c], (mhy[c] - mhy[c-1]) - (mhx[c] - mhx[c-NX]));
    end
    for (int c = 0; c < NC; c++) mez[c] = nez[c];
  endtask

  task automatic host_wr(input int sel, input int addr, input longint val);
    @(negedge clk);
    host_we    = 1'b1;
    host_sel   = 2'(sel);
    host_addr  = AW'(addr);
    host_wdata = DW'(val);
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic host_rd(input int sel, input int addr, output longint val);
    @(negedge clk);
    host_sel  = 2'(sel);
    host_addr = AW'(addr);
    @(negedge clk);
    val = longint'($signed(host_rdata));
  endtask

  task automatic load(input int sh);
    longint v;
    for (int c = 0; c < NC; c++) begin
      for (int f = 0; f < 3; f++) begin
        v = longint'(((c * 37 + f * 101 + sh) % 200) - 100) <<< sh;
        if (f == 0) mez[c] = v;
        else if (f == 1) mhx[c] = v;
        else mhy[c] = v;
        host_wr(f, c, v);
      end
    end
  endtask

  task automatic cmp_all(input string th, input string te);
    longint act, exp;
    string  tag;
    for (int c = 0; c < NC; c++) begin
      for (int f = 0; f < 3; f++) begin
        host_rd(f, c, act);
        exp = (f == 0) ? mez[c] : (f == 1) ? mhx[c] : mhy[c];
        tag = ring(c) ? "R5" : ((f == 0) ? te : th);
        check(act == exp, tag, $sformatf("field %0d cell %0d", f, c), act, exp);
      end
    end
  endtask

  task automatic run_step(input longint ah, input longint bh, input longint ae,
                          input longint be, input bit disturb);
    @(negedge clk);
    cah = DW'(ah);
    cbh = DW'(bh);
    cae = DW'(ae);
    cbe = DW'(be);
    step_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", longint'(busy), 1);
    for (int k = 1; k <= LIM; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(done == (k == LIM), "R6", $sformatf("step_done at edge %0d", k),
            longint'(done), longint'(k == LIM));
      check(busy == (k < LIM), "R6", $sformatf("busy at edge %0d", k),
            longint'(busy), longint'(k < LIM));
      if (disturb && k == 40) begin
        // R7 / R9: coefficient change, host write and restart while busy
        cah = '0; cbh = '0; cae = '0; cbe = '0;
        host_we = 1'b1; host_sel = 2'd0;
        host_addr = AW'(PLANE + 5 * NX + 5); host_wdata = DW'(123456);
        step_start = 1'b1;
      end
      if (disturb && k == 41) begin
        host_we = 1'b0;
        step_start = 1'b0;
      end
    end
    model_step(ah, bh, ae, be);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual no finish expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    longint v;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R6", "busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R6", "done in reset", longint'(done), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R6", "busy after reset", longint'(busy), 0);

    load(18);
    host_rd(0, 17, v);   check(v == mez[17], "R8", "Ez readback", v, mez[17]);
    host_rd(1, 300, v);  check(v == mhx[300], "R8", "Hx readback", v, mhx[300]);
    host_rd(2, 0, v);    check(v == mhy[0], "R8", "Hy readback", v, mhy[0]);

    // magnetic then electric update, ring zeroed
    run_step(ONE, ONE / 4, ONE, ONE / 2, 1'b0);
    cmp_all("R3", "R4");

    // mid-step coefficient change, host write and restart ignored
    run_step((ONE * 9) / 10, (ONE * 3) / 10, (ONE * 19) / 20, (ONE * 9) / 20, 1'b1);
    cmp_all("R7", "R9");

    // inexact coefficients exercise rounding
    run_step(ONE - 7, ONE / 3, -(ONE / 3), ONE / 7, 1'b0);
    cmp_all("R1", "R1");

    // large values and gains drive saturation
    load(22);
    run_step(longint'(7.9 * 67108864.0), longint'(7.9 * 67108864.0),
             longint'(-7.9 * 67108864.0), longint'(7.9 * 67108864.0), 1'b0);
    cmp_all("R2", "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule